// File: doc/BRIEF.md
# Watchdog Timer with Early Warning Interrupt

This block is a free-running watchdog counter driven by the system clock. A two-bit select input chooses one of four power-of-two expiry lengths. When the counter reaches the chosen length, a sticky warning flag is raised. A fixed grace period of 512 clocks follows. If software does not restart the counter during that period, a sticky reset flag is raised. When the reset enable is on, a one-clock reset request is also issued. The counter then wraps to zero and keeps running.

Software must restart the counter before expiry to keep both flags quiet. Two controls are protected: the reset enable and the restart strobe. They are accepted only inside a short unlock window. The window opens when the key byte 8'hAA is written, followed on the next clock by 8'h55. The warning output is the warning flag gated by a plain interrupt enable. The reset enable affects only the reset request. A parameter shortens every expiry length by a power of two, so that all four select codes can be exercised in a short run.

Top module: `wdog_warn`

## Requirements
- R1: While and right after the synchronous active-low reset, both flags, the warning output, the reset request and the reset enable are 0, and the counter starts from zero.
- R2: With SCALE_SH = s, select codes 0, 1, 2 and 3 give expiry lengths L of 2^(17-s), 2^(20-s), 2^(23-s) and 2^(26-s) clocks. The warning flag reads 1 after exactly L rising edges following reset release or an accepted restart, and reads 0 after L-1 edges.
- R3: The warning flag sets whatever the interrupt enable is. The warning output equals the flag ANDed with the enable.
- R4: The reset flag sets exactly 512 edges after the warning flag sets, that is L+512 edges after the time origin.
- R5: At the reset flag's set edge, a reset request pulse lasting one clock is produced, but only if the reset enable is 1. With the enable at 0, no request appears.
- R6: After the reset point the counter wraps to zero without a restart and keeps running. The warning condition recurs L edges later.
- R7: The unlock window opens when a key write of 8'hAA is followed on the next clock by a key write of 8'h55. A protected write is accepted in each of the 4 clocks that follow the 8'h55 write.
- R8: A reset-enable write or a restart presented outside the unlock window is ignored.
- R9: An accepted restart zeroes the counter and cancels any pending grace period. Issued before expiry, it prevents the warning. Issued during the grace period, it prevents the reset flag.
- R10: Both flags stay set until their own clear strobe is applied. If a set and a clear fall on the same edge, the set wins.
- R11: A change of the select code does not restart the counter. A new length at or below the current count expires on the next edge, and a longer one expires when the running count reaches it.
- R12: If a key write of 8'hAA is separated from the 8'h55 write by an idle clock, the window does not open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 2 | Expiry length select |
| irq_en_i | input | 1 | Warning output enable |
| rst_en_wr_i | input | 1 | Protected write strobe for the reset enable |
| rst_en_val_i | input | 1 | Value for the reset enable write |
| restart_i | input | 1 | Protected counter restart strobe |
| clr_irq_i | input | 1 | Clears the warning flag |
| clr_rst_i | input | 1 | Clears the reset flag |
| ta_wr_i | input | 1 | Key byte write strobe |
| ta_byte_i | input | 8 | Key byte |
| irq_flag_o | output | 1 | Sticky warning flag |
| rst_flag_o | output | 1 | Sticky reset flag |
| irq_o | output | 1 | Gated warning output |
| rst_req_o | output | 1 | One-clock reset request |
| rst_en_o | output | 1 | Current reset enable |

## Verification
The bench builds the block with SCALE_SH = 12. This turns the four expiry lengths into 32, 256, 2048 and 16384 clocks, while the grace period stays at its full 512 clocks. At these lengths every select code can be swept, each with its exact warning edge and reset edge, and the wrap to a second expiry fits in the run. The short lengths also make restart timing, select changes and unlock window edges checkable to the single clock.

// File: rtl/wdog_pkg.sv
// Package: shared constants and types for the watchdog block.
// Assumes: nothing beyond IEEE 1800-2017.
package wdog_pkg;
    // First and second key bytes of the unlock sequence.
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    // Counter phase: counting toward expiry, or inside the grace period.
    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_GRACE = 1'b1
    } wd_phase_e;
endpackage

// File: rtl/wdog_unlock.sv
// Module: unlock window generator.
// Opens a window of WIN_CLKS clocks once KEY_FIRST and then KEY_SECOND
// are written on consecutive clocks. A new sequence reloads the window.
// Assumes: key writes come as one-clock strobes on ta_wr_i.
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter int WIN_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ta_wr_i,
    input  logic [7:0] ta_byte_i,
    output logic       win_open_o
);
    localparam int WW = $clog2(WIN_CLKS + 1);

    logic          first_seen;
    logic [WW-1:0] win_left;
    logic          key_done;

    assign key_done = first_seen && ta_wr_i && (ta_byte_i == KEY_SECOND);

    // Remember whether the previous clock carried the first key byte.
    always_ff @(posedge clk) begin
        if (!rst_n) first_seen <= 1'b0;
        else        first_seen <= ta_wr_i && (ta_byte_i == KEY_FIRST);
    end

    // Load the window on a completed key, then count it down to closed.
    always_ff @(posedge clk) begin
        if (!rst_n)              win_left <= '0;
        else if (key_done)       win_left <= WW'(WIN_CLKS);
        else if (win_left != '0) win_left <= win_left - 1'b1;
    end

    assign win_open_o = (win_left != '0);
endmodule

// File: rtl/wdog_count.sv
// Module: free-running expiry counter with a fixed grace period.
// Counts from zero after reset. The select picks one of four
// power-of-two lengths, each shortened by SCALE_SH. On reaching it, the
// module pulses irq_set_o and enters a grace period of GRACE_CLKS
// clocks. At the end of the grace period it pulses rst_set_o and wraps
// to zero. A qualified restart zeroes everything and wins over both pulses.
// Assumes: SCALE_SH <= EXP_MIN - 2, so every length is at least 4.
module wdog_count
    import wdog_pkg::*;
#(
    parameter int EXP_MIN    = 17,
    parameter int EXP_STEP   = 3,
    parameter int SCALE_SH   = 0,
    parameter int GRACE_CLKS = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic       restart_i,
    output logic       irq_set_o,
    output logic       rst_set_o
);
    localparam int NSEL    = 4;
    localparam int EXP_TOP = EXP_MIN + (NSEL - 1) * EXP_STEP - SCALE_SH;
    localparam int CW      = EXP_TOP + 1;
    localparam int GW      = $clog2(GRACE_CLKS);

    logic [CW-1:0] last_cnt [NSEL];
    logic [CW-1:0] cnt;
    logic [GW-1:0] gcnt;
    wd_phase_e     phase;
    logic          expire;
    logic          grace_end;

    // One terminal count per select code, computed from the parameters.
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        localparam int SH = EXP_MIN + g * EXP_STEP - SCALE_SH;
        assign last_cnt[g] = (CW'(1) << SH) - CW'(1);
    end

    // Compare against the current select so a change applies at once.
    assign expire    = (phase == PH_RUN) && (cnt >= last_cnt[sel_i]);
    assign grace_end = (phase == PH_GRACE) && (gcnt == GW'(GRACE_CLKS - 1));

    assign irq_set_o = expire && !restart_i;
    assign rst_set_o = grace_end && !restart_i;

    // Advance the counter, step between phases and honour restarts.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt   <= '0;
            gcnt  <= '0;
            phase <= PH_RUN;
        end else if (phase == PH_RUN) begin
            if (expire) begin
                phase <= PH_GRACE;
                gcnt  <= '0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (grace_end) begin
                phase <= PH_RUN;
                cnt   <= '0;
            end else begin
                gcnt <= gcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdog_flags.sv
// Module: sticky flags, reset enable register and output gating.
// Flags set on the counter's pulses and clear on their strobes, with set
// taking priority. The reset request is a registered one-clock pulse.
// Assumes: en_wr_i is already qualified by the unlock window.
module wdog_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_set_i,
    input  logic rst_set_i,
    input  logic clr_irq_i,
    input  logic clr_rst_i,
    input  logic en_wr_i,
    input  logic en_val_i,
    input  logic irq_en_i,
    output logic irq_flag_o,
    output logic rst_flag_o,
    output logic irq_o,
    output logic rst_req_o,
    output logic rst_en_o
);
    logic irq_flag;
    logic rst_flag;
    logic rst_en;
    logic rst_req;

    // Warning flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_flag <= 1'b0;
        else if (irq_set_i) irq_flag <= 1'b1;
        else if (clr_irq_i) irq_flag <= 1'b0;
    end

    // Reset flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         rst_flag <= 1'b0;
        else if (rst_set_i) rst_flag <= 1'b1;
        else if (clr_rst_i) rst_flag <= 1'b0;
    end

    // Reset enable, written only through the qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rst_en <= 1'b0;
        else if (en_wr_i) rst_en <= en_val_i;
    end

    // One-clock reset request at the reset point when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= rst_set_i && rst_en;
    end

    assign irq_flag_o = irq_flag;
    assign rst_flag_o = rst_flag;
    assign irq_o      = irq_flag && irq_en_i;
    assign rst_req_o  = rst_req;
    assign rst_en_o   = rst_en;
endmodule

// File: rtl/wdog_warn.sv
// Module: watchdog top level.
// Ties the unlock window, the expiry counter and the flag logic together.
// Protected writes are qualified by the window here.
// Assumes: all inputs are synchronous to clk.
module wdog_warn #(
    parameter int EXP_MIN    = 17,
    parameter int EXP_STEP   = 3,
    parameter int SCALE_SH   = 0,
    parameter int GRACE_CLKS = 512,
    parameter int WIN_CLKS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic       irq_en_i,
    input  logic       rst_en_wr_i,
    input  logic       rst_en_val_i,
    input  logic       restart_i,
    input  logic       clr_irq_i,
    input  logic       clr_rst_i,
    input  logic       ta_wr_i,
    input  logic [7:0] ta_byte_i,
    output logic       irq_flag_o,
    output logic       rst_flag_o,
    output logic       irq_o,
    output logic       rst_req_o,
    output logic       rst_en_o
);
    logic win_open;
    logic restart_ok;
    logic en_wr_ok;
    logic irq_set_w;
    logic rst_set_w;

    assign restart_ok = restart_i && win_open;
    assign en_wr_ok   = rst_en_wr_i && win_open;

    wdog_unlock #(
        .WIN_CLKS (WIN_CLKS)
    ) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .ta_wr_i    (ta_wr_i),
        .ta_byte_i  (ta_byte_i),
        .win_open_o (win_open)
    );

    wdog_count #(
        .EXP_MIN    (EXP_MIN),
        .EXP_STEP   (EXP_STEP),
        .SCALE_SH   (SCALE_SH),
        .GRACE_CLKS (GRACE_CLKS)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel_i),
        .restart_i (restart_ok),
        .irq_set_o (irq_set_w),
        .rst_set_o (rst_set_w)
    );

    wdog_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_set_i  (irq_set_w),
        .rst_set_i  (rst_set_w),
        .clr_irq_i  (clr_irq_i),
        .clr_rst_i  (clr_rst_i),
        .en_wr_i    (en_wr_ok),
        .en_val_i   (rst_en_val_i),
        .irq_en_i   (irq_en_i),
        .irq_flag_o (irq_flag_o),
        .rst_flag_o (rst_flag_o),
        .irq_o      (irq_o),
        .rst_req_o  (rst_req_o),
        .rst_en_o   (rst_en_o)
    );
endmodule

// File: rtl/wdog_warn_chk.sv
// Module: property checker for wdog_warn, attached with bind.
// Keeps its own count of the grace period, so that the window length is
// checked without a deep $past.
// Assumes: it is connected to the top level's internal qualified strobes.
module wdog_warn_chk #(
    parameter int GRACE_CLKS = 512
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ta_wr_i,
    input logic [7:0] ta_byte_i,
    input logic       clr_irq_i,
    input logic       irq_flag_o,
    input logic       rst_req_o,
    input logic       rst_en_o,
    input logic       win_open,
    input logic       restart_ok,
    input logic       irq_set_w,
    input logic       rst_set_w
);
    logic        in_grace;
    logic [15:0] gseen;

    // Independent model of the grace period between the two set pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_ok || rst_set_w) begin
            in_grace <= 1'b0;
            gseen    <= '0;
        end else if (irq_set_w) begin
            in_grace <= 1'b1;
            gseen    <= '0;
        end else if (in_grace) begin
            gseen <= gseen + 1'b1;
        end
    end

    a_r4_grace_length: assert property (@(posedge clk) disable iff (!rst_n)
        rst_set_w |-> (in_grace && gseen == 16'(GRACE_CLKS - 1)));

    a_r5_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(rst_en_o));

    a_r5_req_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    a_r8_enable_moves_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rst_en_o) |-> $past(win_open));

    a_r7_window_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(ta_wr_i && ta_byte_i == 8'h55));

    a_r9_restart_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        restart_ok |=> (!irq_set_w && !rst_set_w));

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag_o) |-> $past(clr_irq_i));
endmodule

bind wdog_warn wdog_warn_chk #(
    .GRACE_CLKS (GRACE_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ta_wr_i    (ta_wr_i),
    .ta_byte_i  (ta_byte_i),
    .clr_irq_i  (clr_irq_i),
    .irq_flag_o (irq_flag_o),
    .rst_req_o  (rst_req_o),
    .rst_en_o   (rst_en_o),
    .win_open   (win_open),
    .restart_ok (restart_ok),
    .irq_set_w  (irq_set_w),
    .rst_set_w  (rst_set_w)
);

// File: tb/sim_wdog_warn.sv
`timescale 1ns/1ps
// Bench: sweeps every select code and the timing edges at reduced lengths.
module sim_wdog_warn;
    localparam int SCALE = 12;
    localparam int GRACE = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_i = 2'd0;
    logic       irq_en_i = 1'b0;
    logic       rst_en_wr_i = 1'b0;
    logic       rst_en_val_i = 1'b0;
    logic       restart_i = 1'b0;
    logic       clr_irq_i = 1'b0;
    logic       clr_rst_i = 1'b0;
    logic       ta_wr_i = 1'b0;
    logic [7:0] ta_byte_i = 8'h00;
    logic       irq_flag_o, rst_flag_o, irq_o, rst_req_o, rst_en_o;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    wdog_warn #(.SCALE_SH(SCALE)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .irq_en_i(irq_en_i),
        .rst_en_wr_i(rst_en_wr_i), .rst_en_val_i(rst_en_val_i),
        .restart_i(restart_i), .clr_irq_i(clr_irq_i), .clr_rst_i(clr_rst_i),
        .ta_wr_i(ta_wr_i), .ta_byte_i(ta_byte_i),
        .irq_flag_o(irq_flag_o), .rst_flag_o(rst_flag_o), .irq_o(irq_o),
        .rst_req_o(rst_req_o), .rst_en_o(rst_en_o)
    );

    function automatic int len(int s);
        return 1 << (17 + 3 * s - SCALE);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sel_i = 2'd0; irq_en_i = 1'b0; rst_en_wr_i = 1'b0;
        rst_en_val_i = 1'b0; restart_i = 1'b0; clr_irq_i = 1'b0;
        clr_rst_i = 1'b0; ta_wr_i = 1'b0; ta_byte_i = 8'h00;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic unlock();
        ta_wr_i = 1'b1; ta_byte_i = 8'hAA; step(1);
        ta_byte_i = 8'h55; step(1);
        ta_wr_i = 1'b0; ta_byte_i = 8'h00;
    endtask

    task automatic write_en(logic v, int gap);
        step(gap);
        rst_en_wr_i = 1'b1; rst_en_val_i = v; step(1);
        rst_en_wr_i = 1'b0;
    endtask

    task automatic do_restart();
        restart_i = 1'b1; step(1);
        restart_i = 1'b0;
    endtask

    initial begin
        step(150000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // R1, R2, R3, R4, R5, R6, R10 on select code 0
        do_reset();
        chk("R1 irq_flag", irq_flag_o, 1'b0);
        chk("R1 rst_flag", rst_flag_o, 1'b0);
        chk("R1 irq_o", irq_o, 1'b0);
        chk("R1 rst_req", rst_req_o, 1'b0);
        chk("R1 rst_en", rst_en_o, 1'b0);
        step(len(0) - 1);
        chk("R2 before expiry", irq_flag_o, 1'b0);
        step(1);
        chk("R2 at expiry", irq_flag_o, 1'b1);
        chk("R3 masked output", irq_o, 1'b0);
        irq_en_i = 1'b1; #1;
        chk("R3 enabled output", irq_o, 1'b1);
        step(GRACE - 1);
        chk("R4 before reset point", rst_flag_o, 1'b0);
        step(1);
        chk("R4 at reset point", rst_flag_o, 1'b1);
        chk("R5 no request when disabled", rst_req_o, 1'b0);
        clr_irq_i = 1'b1; clr_rst_i = 1'b1; step(1);
        clr_irq_i = 1'b0; clr_rst_i = 1'b0;
        chk("R10 irq clear", irq_flag_o, 1'b0);
        chk("R10 rst clear", rst_flag_o, 1'b0);
        step(len(0) - 2);
        chk("R6 before second expiry", irq_flag_o, 1'b0);
        step(1);
        chk("R6 second expiry", irq_flag_o, 1'b1);

        // R2, R4 sweep over every select code
        for (int s = 0; s < 4; s++) begin
            do_reset();
            sel_i = 2'(s);
            step(len(s) - 1);
            chk($sformatf("R2 sel%0d before", s), irq_flag_o, 1'b0);
            step(1);
            chk($sformatf("R2 sel%0d at", s), irq_flag_o, 1'b1);
            step(GRACE - 1);
            chk($sformatf("R4 sel%0d before", s), rst_flag_o, 1'b0);
            step(1);
            chk($sformatf("R4 sel%0d at", s), rst_flag_o, 1'b1);
        end

        // R10 set beats a clear on the same edge, and the flag holds
        do_reset();
        step(len(0) - 1);
        clr_irq_i = 1'b1; step(1); clr_irq_i = 1'b0;
        chk("R10 set wins", irq_flag_o, 1'b1);
        step(100);
        chk("R10 sticky", irq_flag_o, 1'b1);

        // R7, R8 window edges for the reset enable
        do_reset();
        write_en(1'b1, 0);
        chk("R8 write without unlock", rst_en_o, 1'b0);
        unlock();
        write_en(1'b1, 4);
        chk("R8 write after window", rst_en_o, 1'b0);
        unlock();
        write_en(1'b1, 3);
        chk("R7 write in last window clock", rst_en_o, 1'b1);

        // R12 broken key sequence
        do_reset();
        ta_wr_i = 1'b1; ta_byte_i = 8'hAA; step(1);
        ta_wr_i = 1'b0; step(1);
        ta_wr_i = 1'b1; ta_byte_i = 8'h55; step(1);
        ta_wr_i = 1'b0; ta_byte_i = 8'h00;
        write_en(1'b1, 0);
        chk("R12 gap in key", rst_en_o, 1'b0);

        // R5 reset request pulse with enable set
        do_reset();
        unlock();
        write_en(1'b1, 0);
        chk("R7 first window clock", rst_en_o, 1'b1);
        do_restart();
        step(len(0) + GRACE - 1);
        chk("R5 no early request", rst_req_o, 1'b0);
        step(1);
        chk("R5 request", rst_req_o, 1'b1);
        step(1);
        chk("R5 single clock", rst_req_o, 1'b0);

        // R9 restart before expiry
        do_reset();
        step(len(0) - 7);
        unlock();
        do_restart();
        step(10);
        chk("R9 expiry prevented", irq_flag_o, 1'b0);
        step(len(0) - 11);
        chk("R9 new origin before", irq_flag_o, 1'b0);
        step(1);
        chk("R9 new origin at", irq_flag_o, 1'b1);

        // R9 restart during grace, R8 ignored restart
        do_reset();
        step(len(0) + 200);
        do_restart();
        step(GRACE - 200);
        chk("R8 ignored restart keeps reset point", rst_flag_o, 1'b1);
        do_reset();
        step(len(0) + 200);
        unlock();
        do_restart();
        step(400);
        chk("R9 reset prevented", rst_flag_o, 1'b0);
        chk("R9 flag still held", irq_flag_o, 1'b1);

        // R11 select changes
        do_reset();
        sel_i = 2'd3;
        step(100);
        sel_i = 2'd0;
        step(1);
        chk("R11 shorter length expires", irq_flag_o, 1'b1);
        do_reset();
        step(20);
        sel_i = 2'd1;
        step(len(1) - 21);
        chk("R11 longer before", irq_flag_o, 1'b0);
        step(1);
        chk("R11 longer at", irq_flag_o, 1'b1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule